// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that a processor drives through a small 16-bit register window. Software sets a control word, a clock divider and the chip-select pattern, then writes a byte to the transmit register. The block shifts that byte out on the serial data output and captures the same number of bits from the serial data input. The captured byte then appears in the receive register. Three status flags let software poll for progress: transmit word pending, transfer complete and receive data available.

Clock polarity, clock phase and bit order are set in the control word. Each of the seven chip-select outputs has its own enable bit and its own level bit. A select whose enable is clear sits high. If a second byte is written while one is still shifting, it waits and goes out right after the first.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset every register reads zero, the status reads zero, every chip-select output is high, the serial clock is low and the serial data output is high.
- R2: Registers sit at byte offsets control 0x00, select flags 0x04, status 0x08, transmit 0x0C, receive 0x10 and divider 0x14. Control, flags and divider read back the last value written. Any other offset reads zero.
- R3: Chip-select output k (k = 1..7, port bit k-1) drives flags bit 8+k while flags bit k is set. It is high while flags bit k is clear.
- R4: A write to the transmit register sets the pending flag (status bit 1). The byte is loaded one cycle later, and the pending flag clears at that load, only if control bit 14 (enable) and bit 12 (master) are set and control bits 1:0 are 00. Otherwise the byte waits, the pending flag stays set and the serial clock does not move.
- R5: A transfer produces 16 serial clock edges. They are spaced D system cycles apart, where D is the divider value or 2 when the divider is below 2. The first edge comes D cycles after the load.
- R6: Outside a transfer the serial clock sits at control bit 11 (polarity).
- R7: With control bit 10 (phase) clear, the first data bit is on the output before the first edge, input is sampled on edges 1,3,5,... and the output changes on edges 2,4,.... With phase set, input is sampled on edges 2,4,... and the output changes on edges 3,5,.... The serial data output is high outside a transfer.
- R8: With control bit 9 set, bits go out and come in least significant first. With it clear, most significant first.
- R9: On the 16th edge the captured byte is written to the receive register and status bits 0 (done) and 2 (receive full) are set. Reading the receive register clears bit 2. A write to the transmit register clears bit 0.
- R10: A byte written during a transfer is held and loaded on the cycle after the running transfer ends.
- R11: Clearing control bit 14 during a transfer ends it at once. The done flag stays clear and the serial clock returns to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears receive-full on the receive offset) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data output |
| spi_miso | input | 1 | Serial data input |
| spi_cs | output | 7 | Chip-select outputs, bit k-1 for select k |

## Verification
The bench goes after four kinds of fault:
- **Divider floor.** Divider values 0 and 1 must act as 2. A design that skips the floor would toggle the clock every cycle or stall, and the per-cycle clock comparison catches either.
- **Phase and bit order.** These are tested in several combinations, with a byte whose two halves differ. A design that samples on the wrong edge or reverses the order returns a different receive byte and shows data on the wrong cycles.
- **Queued byte.** A byte is written while another is still shifting. A design that overwrites the running byte, or drops the queued one, shows the wrong data on the serial output.
- **Ignored starts and aborts.** A transmit write under a disabled or non-zero start mode must leave the clock idle. An abort must leave the done flag clear.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    localparam int unsigned REG_W = 16;

    localparam logic [4:0] OFF_CTRL  = 5'h00;
    localparam logic [4:0] OFF_FLAGS = 5'h04;
    localparam logic [4:0] OFF_STAT  = 5'h08;
    localparam logic [4:0] OFF_TX    = 5'h0C;
    localparam logic [4:0] OFF_RX    = 5'h10;
    localparam logic [4:0] OFF_DIV   = 5'h14;

    localparam int unsigned CB_ENABLE = 14;
    localparam int unsigned CB_MASTER = 12;
    localparam int unsigned CB_CPOL   = 11;
    localparam int unsigned CB_CPHA   = 10;
    localparam int unsigned CB_LSB    = 9;

    localparam int unsigned SB_DONE = 0;
    localparam int unsigned SB_TXF  = 1;
    localparam int unsigned SB_RXF  = 2;

    localparam logic [REG_W-1:0] DIV_FLOOR = 16'd2;
endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int unsigned WORD_BITS = 8,
    parameter int unsigned ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              load_i,
    input  logic              finish_i,
    input  logic [WORD_BITS-1:0] rx_word_i,
    output logic [REG_W-1:0]  ctrl_o,
    output logic [REG_W-1:0]  flags_o,
    output logic [REG_W-1:0]  eff_div_o,
    output logic [WORD_BITS-1:0] tx_word_o,
    output logic              tx_full_o
);
    typedef struct packed {
        logic [REG_W-1:0]     ctrl;
        logic [REG_W-1:0]     flags;
        logic [REG_W-1:0]     div;
        logic [WORD_BITS-1:0] tx_buf;
        logic [WORD_BITS-1:0] rx_buf;
        logic                 tx_full;
        logic                 rx_full;
        logic                 done;
    } regs_t;

    regs_t q, d;
    logic  wr_tx;
    logic  rd_rx;

    assign wr_tx = wr_i && (addr_i == OFF_TX);
    assign rd_rx = rd_i && (addr_i == OFF_RX);

    always_comb begin
        d = q;
        if (load_i) d.tx_full = 1'b0;
        if (rd_rx)  d.rx_full = 1'b0;
        if (wr_i) begin
            case (addr_i)
                OFF_CTRL:  d.ctrl  = wdata_i;
                OFF_FLAGS: d.flags = wdata_i;
                OFF_DIV:   d.div   = wdata_i;
                OFF_TX: begin
                    d.tx_buf  = wdata_i[WORD_BITS-1:0];
                    d.tx_full = 1'b1;
                    d.done    = 1'b0;
                end
                default: ;
            endcase
        end
        if (finish_i) begin
            d.rx_buf  = rx_word_i;
            d.rx_full = 1'b1;
            d.done    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFF_CTRL:  rdata_o = q.ctrl;
            OFF_FLAGS: rdata_o = q.flags;
            OFF_DIV:   rdata_o = q.div;
            OFF_TX:    rdata_o[WORD_BITS-1:0] = q.tx_buf;
            OFF_RX:    rdata_o[WORD_BITS-1:0] = q.rx_buf;
            OFF_STAT: begin
                rdata_o[SB_DONE] = q.done;
                rdata_o[SB_TXF]  = q.tx_full;
                rdata_o[SB_RXF]  = q.rx_full;
            end
            default: ;
        endcase
    end

    assign ctrl_o    = q.ctrl;
    assign flags_o   = q.flags;
    assign eff_div_o = (q.div < DIV_FLOOR) ? DIV_FLOOR : q.div;
    assign tx_word_o = q.tx_buf;
    assign tx_full_o = q.tx_full;

    // R4
    txf_clear_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !wr_tx |=> !q.tx_full);

    // R9
    finish_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_i |=> q.rx_full && q.done);
endmodule

// File: rtl/spi_host_clkdiv.sv
module spi_host_clkdiv #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] eff_div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t q, d;

    assign tick_o = run_i && (q.cnt == eff_div_i - 1'b1);

    always_comb begin
        d = q;
        if (!run_i)      d.cnt = '0;
        else if (tick_o) d.cnt = '0;
        else             d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> q.cnt < eff_div_i);
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
    parameter int unsigned WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 abort_i,
    input  logic                 tick_i,
    input  logic                 cpol_i,
    input  logic                 cpha_i,
    input  logic                 lsb_i,
    input  logic                 miso_i,
    input  logic [WORD_BITS-1:0] tx_word_i,
    output logic                 load_o,
    output logic                 finish_o,
    output logic [WORD_BITS-1:0] rx_word_o,
    output logic                 busy_o,
    output logic                 sck_o,
    output logic                 mosi_o
);
    localparam int unsigned N_EDGES = 2 * WORD_BITS;
    localparam int unsigned EDGE_W  = $clog2(N_EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(N_EDGES - 1);

    typedef struct packed {
        logic                 busy;
        logic [EDGE_W-1:0]    edge_idx;
        logic [WORD_BITS-1:0] tx_sh;
        logic [WORD_BITS-1:0] rx_sh;
        logic                 sck;
    } shf_t;

    shf_t q, d;
    logic leading;
    logic do_sample;
    logic do_drive;
    logic [WORD_BITS-1:0] rx_next;

    assign leading   = ~q.edge_idx[0];
    assign do_sample = cpha_i ? ~leading : leading;
    assign do_drive  = cpha_i ? (leading && (q.edge_idx != '0)) : ~leading;

    always_comb begin
        d        = q;
        load_o   = 1'b0;
        finish_o = 1'b0;
        rx_next  = q.rx_sh;
        if (!q.busy) begin
            d.sck = cpol_i;
            if (start_i) begin
                load_o     = 1'b1;
                d.busy     = 1'b1;
                d.edge_idx = '0;
                d.tx_sh    = tx_word_i;
                d.rx_sh    = '0;
            end
        end else if (abort_i) begin
            d.busy = 1'b0;
            d.sck  = cpol_i;
        end else if (tick_i) begin
            d.sck      = ~q.sck;
            d.edge_idx = q.edge_idx + 1'b1;
            if (do_sample) begin
                rx_next = lsb_i ? {miso_i, q.rx_sh[WORD_BITS-1:1]}
                                : {q.rx_sh[WORD_BITS-2:0], miso_i};
            end
            d.rx_sh = rx_next;
            if (do_drive) begin
                d.tx_sh = lsb_i ? (q.tx_sh >> 1) : (q.tx_sh << 1);
            end
            if (q.edge_idx == LAST_EDGE) begin
                finish_o = 1'b1;
                d.busy   = 1'b0;
                d.sck    = cpol_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_word_o = rx_next;
    assign busy_o    = q.busy;
    assign sck_o     = q.busy ? q.sck : cpol_i;
    assign mosi_o    = q.busy ? (lsb_i ? q.tx_sh[0] : q.tx_sh[WORD_BITS-1]) : 1'b1;

    // R5
    sck_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && !tick_i && !abort_i |=> $stable(q.sck));

    // R5
    finish_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |-> q.edge_idx == LAST_EDGE);

    // R11
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && abort_i |=> !q.busy);
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int unsigned WORD_BITS = 8,
    parameter int unsigned NUM_CS    = 7,
    parameter int unsigned ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs
);
    logic [REG_W-1:0]     ctrl;
    logic [REG_W-1:0]     flags;
    logic [REG_W-1:0]     eff_div;
    logic [WORD_BITS-1:0] tx_word;
    logic [WORD_BITS-1:0] rx_word;
    logic                 tx_full;
    logic                 load;
    logic                 finish;
    logic                 busy;
    logic                 tick;
    logic                 start_req;
    logic                 abort_req;
    logic                 unused_bits;

    assign abort_req = ~ctrl[CB_ENABLE];
    assign start_req = tx_full && ctrl[CB_ENABLE] && ctrl[CB_MASTER] && (ctrl[1:0] == 2'b00);
    assign unused_bits = ^{ctrl, flags};

    spi_host_regs #(.WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .wr_i      (bus_wr),
        .rd_i      (bus_rd),
        .wdata_i   (bus_wdata),
        .rdata_o   (bus_rdata),
        .load_i    (load),
        .finish_i  (finish),
        .rx_word_i (rx_word),
        .ctrl_o    (ctrl),
        .flags_o   (flags),
        .eff_div_o (eff_div),
        .tx_word_o (tx_word),
        .tx_full_o (tx_full)
    );

    spi_host_clkdiv #(.CNT_W(REG_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy),
        .eff_div_i (eff_div),
        .tick_o    (tick)
    );

    spi_host_shifter #(.WORD_BITS(WORD_BITS)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_req),
        .abort_i   (abort_req),
        .tick_i    (tick),
        .cpol_i    (ctrl[CB_CPOL]),
        .cpha_i    (ctrl[CB_CPHA]),
        .lsb_i     (ctrl[CB_LSB]),
        .miso_i    (spi_miso),
        .tx_word_i (tx_word),
        .load_o    (load),
        .finish_o  (finish),
        .rx_word_o (rx_word),
        .busy_o    (busy),
        .sck_o     (spi_sck),
        .mosi_o    (spi_mosi)
    );

    generate
        for (genvar k = 1; k <= NUM_CS; k++) begin : g_cs
            assign spi_cs[k-1] = flags[k] ? flags[8+k] : 1'b1;
        end
    endgenerate

    // R4
    no_start_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !ctrl[CB_ENABLE] |=> !busy);
endmodule

// File: tb/sim_spi_host_ctrl.sv
module sim_spi_host_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;
    logic [6:0]  spi_cs;

    int total = 0;
    int bad = 0;
    bit done_run = 0;

    always #4 clk = ~clk;

    spi_host_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
    );

    // behavioural reference state
    logic [15:0] m_ctrl, m_flags, m_div;
    logic [7:0]  m_txbuf, m_rx, m_byte, m_acc;
    bit          m_txf, m_rxf, m_done, m_busy, m_sck;
    int          m_cnt, m_edge, m_nsh, m_nsm;
    logic [7:0]  slave_byte = 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int eb;
        bit go, lead, smp, drv, fin, ld;
        if (!rst_n) begin
            m_ctrl = 0; m_flags = 0; m_div = 0; m_txbuf = 0; m_rx = 0;
            m_txf = 0; m_rxf = 0; m_done = 0; m_busy = 0; m_sck = 0;
            m_cnt = 0; m_edge = 0; m_nsh = 0; m_nsm = 0; m_byte = 0; m_acc = 0;
        end else begin
            eb  = (m_div < 2) ? 2 : int'(m_div);
            go  = m_ctrl[14] && m_ctrl[12] && (m_ctrl[1:0] == 2'b00);
            fin = 0; ld = 0;
            if (!m_busy) begin
                if (go && m_txf) begin
                    ld = 1; m_busy = 1; m_edge = 0; m_cnt = 0;
                    m_nsh = 0; m_nsm = 0; m_byte = m_txbuf; m_acc = 0;
                    m_sck = m_ctrl[11];
                end
            end else if (!m_ctrl[14]) begin
                m_busy = 0;
            end else if (m_cnt == eb - 1) begin
                m_cnt = 0;
                lead = (m_edge % 2) == 0;
                smp  = m_ctrl[10] ? !lead : lead;
                drv  = m_ctrl[10] ? (lead && m_edge > 0) : !lead;
                if (smp && m_nsm < 8) begin
                    m_acc[m_ctrl[9] ? m_nsm : 7 - m_nsm] = spi_miso;
                    m_nsm++;
                end
                if (drv) m_nsh++;
                m_sck = !m_sck;
                if (m_edge == 15) begin fin = 1; m_busy = 0; end
                m_edge++;
            end else begin
                m_cnt++;
            end
            if (ld) m_txf = 0;
            if (bus_rd && bus_addr == 5'h10) m_rxf = 0;
            if (bus_wr) begin
                case (bus_addr)
                    5'h00: m_ctrl = bus_wdata;
                    5'h04: m_flags = bus_wdata;
                    5'h14: m_div = bus_wdata;
                    5'h0C: begin m_txbuf = bus_wdata[7:0]; m_txf = 1; m_done = 0; end
                    default: ;
                endcase
            end
            if (fin) begin m_rx = m_acc; m_rxf = 1; m_done = 1; end
        end
    end

    function automatic logic [6:0] exp_cs();
        logic [6:0] r;
        for (int k = 1; k <= 7; k++) r[k-1] = m_flags[k] ? m_flags[8+k] : 1'b1;
        return r;
    endfunction

    // slave drives the next bit it owes
    always @(negedge clk) begin
        if (m_nsm < 8) spi_miso <= slave_byte[m_ctrl[9] ? m_nsm : 7 - m_nsm];
    end

    // per-cycle comparison, mid high phase
    always @(posedge clk) begin
        logic exp_sck, exp_mosi;
        #2;
        if (rst_n && !done_run) begin
            exp_sck  = m_busy ? m_sck : m_ctrl[11];
            exp_mosi = 1'b1;
            if (m_busy && m_nsh < 8) exp_mosi = m_byte[m_ctrl[9] ? m_nsh : 7 - m_nsh];
            chk(spi_sck == exp_sck, "R5/R6 sck", spi_sck, exp_sck);
            chk(spi_mosi == exp_mosi, "R7/R8 mosi", spi_mosi, exp_mosi);
            chk(spi_cs == exp_cs(), "R3 cs", spi_cs, exp_cs());
        end
    end

    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(bus_rdata == exp, req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(5'h08, 16'h0000, "R1 status");
        rd(5'h00, 16'h0000, "R1 ctrl");
        chk(spi_cs == 7'h7F, "R1 cs", spi_cs, 7'h7F);
        chk(spi_sck == 1'b0 && spi_mosi == 1'b1, "R1 pins", {spi_sck, spi_mosi}, 2'b01);

        // R2 readback
        wr(5'h14, 16'hBEEF);
        rd(5'h14, 16'hBEEF, "R2 divider");
        wr(5'h04, 16'hA5C3);
        rd(5'h04, 16'hA5C3, "R2 flags");
        rd(5'h18, 16'h0000, "R2 unmapped");
        // R3 select patterns
        wr(5'h04, 16'h0E1E); idle(2);
        chk(spi_cs == 7'b1110111, "R3 mix", spi_cs, 7'b1110111);
        wr(5'h04, 16'h00FE); idle(2);
        chk(spi_cs == 7'h00, "R3 all low", spi_cs, 7'h00);

        // R4 write while disabled: held, no clock
        wr(5'h14, 16'h0000);
        wr(5'h0C, 16'h003C);
        idle(20);
        rd(5'h08, 16'h0002, "R4 pending held");
        // R4 non-zero start mode also blocks
        wr(5'h00, 16'h5001);
        idle(20);
        rd(5'h08, 16'h0002, "R4 mode 01 no start");

        // R5 floor, R7 phase 0, R8 msb first: start by selecting mode 00
        slave_byte = 8'hC6;
        wr(5'h00, 16'h5000);
        idle(40);
        rd(5'h08, 16'h0005, "R9 done and rx full");
        rd(5'h10, 16'h00C6, "R9 rx byte msb");
        rd(5'h08, 16'h0001, "R9 rx full cleared by read");

        // R6 R7 R8: polarity 1, phase 1, lsb first, divider 3
        slave_byte = 8'h2D;
        wr(5'h14, 16'h0003);
        wr(5'h00, 16'h5E00);
        idle(2);
        chk(spi_sck == 1'b1, "R6 idle high", spi_sck, 1);
        wr(5'h0C, 16'h00B1);
        rd(5'h08, 16'h0000, "R9 done cleared by tx write");
        idle(60);
        rd(5'h10, 16'h002D, "R8 rx byte lsb");

        // R7 phase 1 polarity 0, divider 1 acts as 2
        slave_byte = 8'h93;
        wr(5'h14, 16'h0001);
        wr(5'h00, 16'h5400);
        wr(5'h0C, 16'h0067);
        idle(45);
        rd(5'h10, 16'h0093, "R7 rx byte phase 1");

        // R10 queued byte
        slave_byte = 8'h5A;
        wr(5'h14, 16'h0002);
        wr(5'h00, 16'h5200);
        wr(5'h0C, 16'h00F0);
        idle(4);
        wr(5'h0C, 16'h000F);
        rd(5'h08, 16'h0002, "R10 second byte pending");
        idle(80);
        rd(5'h08, 16'h0005, "R10 both done");
        rd(5'h10, 16'h005A, "R10 rx of second");

        // R11 abort mid transfer
        wr(5'h14, 16'h0005);
        wr(5'h00, 16'h5000);
        wr(5'h0C, 16'h00AA);
        idle(30);
        wr(5'h00, 16'h0000);
        idle(3);
        chk(spi_sck == 1'b0, "R11 sck idle after abort", spi_sck, 0);
        rd(5'h08, 16'h0000, "R11 no done after abort");
        idle(100);
        rd(5'h08, 16'h0000, "R11 stays stopped");

        done_run = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule